// File: doc/BRIEF.md
# E1 Remote and AIS Alarm Detector

This block watches a received E1 bit stream, already framed by logic upstream, and raises three maintenance alarms. The remote alarm level follows the A bit carried in timeslot 0 of the frames without the alignment word. It either tracks every A bit or waits for a run of four set A bits before it rises. The AIS level judges the all-ones content of the line over fixed 512-bit windows while basic frame alignment is lost. One window or two consecutive windows are needed before the level changes. The excessive-CRC flag counts the CRC-4 mismatch pulses that a separate checker produces. When one second holds more than 914 of them, the flag is latched until software reads it.

The framer supplies a bit strobe, the bit value, timeslot-0 and non-alignment-frame markers, the bit position inside the timeslot, the out-of-frame flag, the mismatch pulse and a one-second tick. Two mode bits pick the alarm filters. A read strobe clears the CRC flag.

Top module: `e1_alarm_det`

## Requirements
- R1: An A bit is sampled only in a cycle where bit_en, ts0 and nfas are all 1 and bit_pos equals 2 (bit_pos counts 0 to 7 from the first bit of the timeslot). Any other bit leaves rai unchanged and does not break a run of set A bits.
- R2: With rai_filt = 0, an A bit of 1 sets rai on the clock edge that samples it. The new value is visible in the next cycle.
- R3: With rai_filt = 1, rai rises only on the 4th consecutive sampled A bit of 1, and it stays high while further A bits are 1.
- R4: In either mode, a sampled A bit of 0 clears rai and restarts the run count.
- R5: Bits counted by bit_en form back-to-back windows of 512 bits, starting from reset. The window's last bit is included in its zero count.
- R6: With ais_dual = 0, the end of a window with fewer than 3 zeros sets ais if oof is 1 in the window's last bit. A window with 3 or more zeros clears ais. A window with fewer than 3 zeros while oof is 0 leaves ais unchanged. The level updates in the cycle after the last bit.
- R7: With ais_dual = 1, ais is set only when the set condition of R6 holds in two consecutive windows. It is cleared only when the clear condition holds in two consecutive windows.
- R8: Each cycle with crc_err = 1 counts one error. A pulse in the same cycle as sec_tick belongs to the second that is ending.
- R9: At sec_tick, exc_crc is set if that second's count exceeds 914, and the count restarts at zero.
- R10: exc_crc stays set across later seconds until a cycle with exc_rd = 1 clears it. If exc_rd coincides with a tick that sets the flag, the flag stays set.
- R11: After reset, rai, ais and exc_crc are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_en | input | 1 | One received bit is present this cycle |
| rx_bit | input | 1 | Received bit value |
| ts0 | input | 1 | Current bit lies in timeslot 0 |
| nfas | input | 1 | Current frame is a non-alignment frame |
| bit_pos | input | 3 | Bit position inside the timeslot, 0 first |
| oof | input | 1 | Basic frame alignment is lost |
| crc_err | input | 1 | One CRC-4 mismatch pulse |
| sec_tick | input | 1 | One-second boundary pulse |
| rai_filt | input | 1 | 1: remote alarm needs four set A bits in a row |
| ais_dual | input | 1 | 1: AIS changes need two consecutive windows |
| exc_rd | input | 1 | Read strobe of the CRC flag |
| rai | output | 1 | Remote alarm level |
| ais | output | 1 | Alarm indication signal level |
| exc_crc | output | 1 | Sticky excessive-CRC flag |

## Verification
The remote-alarm sweep sends runs of one to six set A bits in both modes. It also places decoy bits in every other bit position, in timeslots other than 0, and in alignment frames. A design with an off-by-one run threshold, or one that lets a decoy zero break a run, would raise the alarm one bit early or never.

The AIS sweep sends windows holding 0 to 5 zeros, with the zeros placed at the start or at the very end. Some windows are sent while oof is 0. A design that drops the last bit from its count, lets the windows drift, or forgets the previous window in dual mode would get some of those windows wrong.

The CRC sequence sends 913, 914 and 915 errors and a pulse that coincides with the tick. It also issues a read together with a tick that sets the flag. A design with a greater-or-equal compare, a lost coincident pulse, or a read that beats the set would misreport the flag.

// File: rtl/e1_alarm_det.sv
module e1_alarm_det #(
  parameter int RAI_RUN   = 4,
  parameter int AIS_WIN   = 512,
  parameter int AIS_ZMIN  = 3,
  parameter int CRC_LIMIT = 914
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bit_en,
  input  logic       rx_bit,
  input  logic       ts0,
  input  logic       nfas,
  input  logic [2:0] bit_pos,
  input  logic       oof,
  input  logic       crc_err,
  input  logic       sec_tick,
  input  logic       rai_filt,
  input  logic       ais_dual,
  input  logic       exc_rd,
  output logic       rai,
  output logic       ais,
  output logic       exc_crc
);
  localparam int RW = $clog2(RAI_RUN + 1);
  localparam int WW = $clog2(AIS_WIN);
  localparam int ZW = $clog2(AIS_ZMIN + 1);
  localparam int CW = $clog2(CRC_LIMIT + 2);
  localparam logic [RW-1:0] RUN_MAX = RW'(RAI_RUN);
  localparam logic [RW-1:0] RUN_PRE = RW'(RAI_RUN - 1);
  localparam logic [WW-1:0] WIN_LAST = WW'(AIS_WIN - 1);
  localparam logic [ZW-1:0] Z_MAX = ZW'(AIS_ZMIN);
  localparam logic [CW-1:0] C_MAX = CW'(CRC_LIMIT + 1);
  localparam logic [CW-1:0] C_LIM = CW'(CRC_LIMIT);

  // remote alarm
  logic          a_stb;
  logic [RW-1:0] run;

  assign a_stb = bit_en && ts0 && nfas && (bit_pos == 3'd2);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run <= '0;
      rai <= 1'b0;
    end else if (a_stb) begin
      if (rx_bit) begin
        if (run != RUN_MAX) run <= run + 1'b1;
        if (!rai_filt || run >= RUN_PRE) rai <= 1'b1;
      end else begin
        run <= '0;
        rai <= 1'b0;
      end
    end
  end

  // alarm indication signal
  logic [WW-1:0] wcnt;
  logic [ZW-1:0] zcnt, zn;
  logic          win_end, few, c_set, c_clr, p_set, p_clr;

  assign win_end = bit_en && (wcnt == WIN_LAST);
  assign zn      = (rx_bit || zcnt == Z_MAX) ? zcnt : zcnt + 1'b1;
  assign few     = zn < Z_MAX;
  assign c_set   = few && oof;
  assign c_clr   = !few;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wcnt  <= '0;
      zcnt  <= '0;
      p_set <= 1'b0;
      p_clr <= 1'b0;
      ais   <= 1'b0;
    end else if (bit_en) begin
      if (win_end) begin
        wcnt  <= '0;
        zcnt  <= '0;
        p_set <= c_set;
        p_clr <= c_clr;
        if (c_set && (!ais_dual || p_set))      ais <= 1'b1;
        else if (c_clr && (!ais_dual || p_clr)) ais <= 1'b0;
      end else begin
        wcnt <= wcnt + 1'b1;
        zcnt <= zn;
      end
    end
  end

  // excessive CRC errors
  logic [CW-1:0] ecnt, ecnt_n;
  logic          over;

  assign ecnt_n = (crc_err && ecnt != C_MAX) ? ecnt + 1'b1 : ecnt;
  assign over   = ecnt_n > C_LIM;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ecnt    <= '0;
      exc_crc <= 1'b0;
    end else begin
      ecnt <= sec_tick ? '0 : ecnt_n;
      if (sec_tick && over) exc_crc <= 1'b1;
      else if (exc_rd)      exc_crc <= 1'b0;
    end
  end
endmodule

module e1_alarm_det_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       bit_en,
  input logic       rx_bit,
  input logic       ts0,
  input logic       nfas,
  input logic [2:0] bit_pos,
  input logic       oof,
  input logic       sec_tick,
  input logic       exc_rd,
  input logic       rai_filt,
  input logic       rai,
  input logic       ais,
  input logic       exc_crc,
  input logic       win_end
);
  logic astb;
  assign astb = bit_en && ts0 && nfas && (bit_pos == 3'd2);

  // R1
  rai_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !astb |=> $stable(rai));
  // R2
  rai_fast_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (astb && rx_bit && !rai_filt) |=> rai);
  // R4
  rai_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (astb && !rx_bit) |=> !rai);
  // R5
  ais_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !win_end |=> $stable(ais));
  // R6
  ais_oof_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (win_end && !oof) |=> !$rose(ais));
  // R9
  exc_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sec_tick |=> !$rose(exc_crc));
  // R10
  exc_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_rd && !sec_tick) |=> !exc_crc);
endmodule

bind e1_alarm_det e1_alarm_det_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .rx_bit(rx_bit), .ts0(ts0),
  .nfas(nfas), .bit_pos(bit_pos), .oof(oof), .sec_tick(sec_tick),
  .exc_rd(exc_rd), .rai_filt(rai_filt), .rai(rai), .ais(ais),
  .exc_crc(exc_crc), .win_end(win_end)
);

// File: tb/e1_alarm_det_test.sv
module e1_alarm_det_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bit_en = 1'b0, rx_bit = 1'b1, ts0 = 1'b0, nfas = 1'b0;
  logic [2:0] bit_pos = 3'd0;
  logic oof = 1'b0, crc_err = 1'b0, sec_tick = 1'b0;
  logic rai_filt = 1'b0, ais_dual = 1'b0, exc_rd = 1'b0;
  logic rai, ais, exc_crc;
  int tests = 0, fails = 0;

  always #10 clk = ~clk;

  e1_alarm_det uut (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .rx_bit(rx_bit), .ts0(ts0),
    .nfas(nfas), .bit_pos(bit_pos), .oof(oof), .crc_err(crc_err),
    .sec_tick(sec_tick), .rai_filt(rai_filt), .ais_dual(ais_dual),
    .exc_rd(exc_rd), .rai(rai), .ais(ais), .exc_crc(exc_crc)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %0b expected %0b", req, act, exp);
    end
  endtask

  task automatic idle();
    bit_en = 0; ts0 = 0; nfas = 0; bit_pos = 0; rx_bit = 1;
    crc_err = 0; sec_tick = 0; exc_rd = 0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0; idle(); oof = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R11 rai", rai, 1'b0);
    chk("R11 ais", ais, 1'b0);
    chk("R11 exc_crc", exc_crc, 1'b0);
  endtask

  task automatic abit(input logic b, input logic t, input logic n, input logic [2:0] p);
    @(negedge clk);
    bit_en = 1; rx_bit = b; ts0 = t; nfas = n; bit_pos = p;
    @(negedge clk);
    idle();
  endtask

  task automatic decoys(input logic b, input logic exp);
    for (int p = 0; p < 8; p++) if (p != 2) begin
      abit(b, 1, 1, 3'(p));
      chk("R1 other bit position", rai, exp);
    end
    abit(b, 0, 1, 3'd2);
    chk("R1 timeslot not 0", rai, exp);
    abit(b, 1, 0, 3'd2);
    chk("R1 alignment frame", rai, exp);
  endtask

  task automatic window(input int z, input logic o, input logic at_end);
    for (int i = 0; i < 512; i++) begin
      @(negedge clk);
      bit_en = 1; oof = o;
      rx_bit = at_end ? !(i >= 512 - z) : !(i < z);
    end
    @(negedge clk);
    idle();
  endtask

  task automatic crc_sec(input int n, input logic tick_err, input logic rd);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); crc_err = 1;
    end
    @(negedge clk);
    crc_err = tick_err; sec_tick = 1; exc_rd = rd;
    @(negedge clk);
    idle();
  endtask

  task automatic rd_flag();
    @(negedge clk); exc_rd = 1;
    @(negedge clk); idle();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int zl[15] = '{0, 2, 5, 1, 0, 3, 4, 0, 2, 3, 1, 3, 3, 2, 2};
    logic ol[15] = '{1, 1, 1, 1, 1, 1, 1, 1, 0, 1, 1, 1, 1, 1, 1};
    logic e, ps, pc, cs, cc, ex;

    // remote alarm, both modes
    for (int m = 0; m < 2; m++) begin
      rai_filt = m[0];
      do_reset();
      for (int n = 1; n <= 6; n++) begin
        for (int k = 1; k <= n; k++) begin
          abit(1, 1, 1, 3'd2);
          chk(m ? "R3 filtered run" : "R2 fast set", rai, m ? (k >= 4) : 1'b1);
        end
        abit(0, 1, 1, 3'd2);
        chk("R4 clear on zero", rai, 1'b0);
      end
      decoys(1'b1, 1'b0);
      repeat (4) abit(1, 1, 1, 3'd2);
      decoys(1'b0, 1'b1);
      abit(0, 1, 1, 3'd2);
      repeat (2) abit(1, 1, 1, 3'd2);
      abit(0, 1, 0, 3'd2);
      abit(0, 0, 1, 3'd2);
      abit(0, 1, 1, 3'd5);
      abit(1, 1, 1, 3'd2);
      chk("R1 run kept across decoys", rai, m ? 1'b0 : 1'b1);
      abit(1, 1, 1, 3'd2);
      chk("R1 run kept across decoys", rai, 1'b1);
      abit(0, 1, 1, 3'd2);
      repeat (3) abit(1, 1, 1, 3'd2);
      abit(0, 1, 1, 3'd2);
      repeat (3) abit(1, 1, 1, 3'd2);
      chk("R4 run restarted", rai, m ? 1'b0 : 1'b1);
    end

    // AIS windows, both modes
    for (int m = 0; m < 2; m++) begin
      rai_filt = 0; ais_dual = m[0];
      do_reset();
      e = 0; ps = 0; pc = 0;
      for (int w = 0; w < 15; w++) begin
        window(zl[w], ol[w], w[0]);
        cs = (zl[w] < 3) && ol[w];
        cc = !(zl[w] < 3);
        if (cs && (!m[0] || ps)) e = 1;
        else if (cc && (!m[0] || pc)) e = 0;
        ps = cs; pc = cc;
        chk(m ? "R7 dual window" : "R6 single window", ais, e);
        if (w == 0) chk("R5 window alignment", ais, m ? 1'b0 : 1'b1);
      end
    end

    // excessive CRC
    do_reset();
    ex = 0;
    crc_sec(0, 0, 0);     chk("R9 no errors", exc_crc, 1'b0);
    crc_sec(914, 0, 0);   chk("R9 at limit", exc_crc, 1'b0);
    crc_sec(913, 1, 0);   chk("R8 coincident pulse at limit", exc_crc, 1'b0);
    crc_sec(500, 0, 0);   crc_sec(500, 0, 0);
    chk("R9 count restarts per second", exc_crc, 1'b0);
    rd_flag();            chk("R10 read of clear flag", exc_crc, 1'b0);
    crc_sec(914, 1, 0);   chk("R8 coincident pulse over limit", exc_crc, 1'b1);
    crc_sec(0, 0, 0);     chk("R10 sticky", exc_crc, 1'b1);
    rd_flag();            chk("R10 clear on read", exc_crc, 1'b0);
    crc_sec(915, 0, 0);   chk("R9 over limit", exc_crc, 1'b1);
    rd_flag();            chk("R10 clear on read", exc_crc, 1'b0);
    crc_sec(1000, 0, 1);  chk("R10 read with set", exc_crc, 1'b1);
    rd_flag();            chk("R10 clear on read", exc_crc, 1'b0);
    crc_sec(10, 0, 1);    chk("R10 read with quiet tick", exc_crc, ex);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule